// File: doc/BRIEF.md
# Single-wire bus master engine

This block is the master side of an open-drain, single-wire, bidirectional bus. A host hands it one command at a time. A command is either a bus reset with a presence check, or the transmission of a single bit. The engine then produces the timed low pulse on the line and releases the line, so that the external pull-up returns it high. For a reset it also listens for a slave's answering low pulse and reports whether one was seen.

All timing is counted in whole microseconds. A tick divider turns the system clock into a one-microsecond strobe, and the divider restarts whenever a command is accepted. Every pulse edge therefore falls a fixed number of system clocks after acceptance. The line leaves the block only as a drive-low enable. Its level comes back on a separate input, which passes through a two-stage synchroniser before any decision uses it.

Commands arrive over a valid/ready handshake. The engine raises `cmd_ready` only while it is idle. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high, and a held `cmd_valid` simply waits. The host must keep the command fields stable until the command has been taken. Completion is a one-cycle `done` strobe. `presence` holds the result of the most recent reset.

Top module: `sw_bus_master`

## Requirements
- R1: `cmd_ready` is high exactly when `busy` is low. A command is taken only on an edge where `cmd_valid` and `cmd_ready` are both high, and `busy` is high in the following cycle. A `cmd_valid` that is held while `busy` is high has no effect on the outputs.
- R2: A command with `cmd_reset`=1 drives `line_drive_low` high from the cycle after acceptance, for RST_LOW_US (480) microseconds, and then releases it.
- R3: During a reset, `presence` reads 0 from the cycle after acceptance. At PRES_SAMPLE_US (70) microseconds after the release, the synchronised line is sampled: `presence` becomes 1 if the line was low and 0 if it was high. The synchroniser delays the line by two clocks, so the value sampled is the line level two clocks before that point.
- R4: A reset keeps `busy` high for RST_LOW_US + RST_RX_US (480 + 480) microseconds in total.
- R5: A command with `cmd_reset`=0 and `cmd_bit`=1 drives the line low for ONE_LOW_US (6) microseconds. The whole slot lasts SLOT_US (65) microseconds of `busy`.
- R6: A command with `cmd_reset`=0 and `cmd_bit`=0 drives the line low for ZERO_LOW_US (60) microseconds. The slot also lasts SLOT_US (65) microseconds, which leaves 5 microseconds of recovery.
- R7: `done` is high for exactly one cycle, which is the first cycle with `busy` low after a command. In that cycle `cmd_ready` is already high, so a held command is taken at the edge that ends the `done` cycle.
- R8: A bit command never changes `presence`.
- R9: After `rst_n` is released, and before any command, `busy`, `done` and `line_drive_low` are 0, `presence` is 0 and `cmd_ready` is 1.
- R10: One microsecond is CLK_PER_US system clocks, counted from the acceptance edge. A low phase of N microseconds is exactly N*CLK_PER_US cycles of `line_drive_low`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Host offers a command |
| cmd_ready | output | 1 | Engine is idle and can take a command |
| cmd_reset | input | 1 | 1 = reset with presence check, 0 = send one bit |
| cmd_bit | input | 1 | Bit value for a bit command |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle strobe when a command completes |
| presence | output | 1 | 1 when the last reset saw a slave answer |
| line_drive_low | output | 1 | Open-drain enable: 1 pulls the line low |
| line_in | input | 1 | Level read back from the line (asynchronous) |

## Verification
The completion strobe of one command and the acceptance of the next can fall in the same cycle. The bench provokes this by keeping `cmd_valid` high across a string of bit commands and changing the command fields after each acceptance. A per-cycle model then expects the next low pulse to start exactly one edge after `done`, with no idle gap and no lost or doubled command. A second coincidence is the presence sample, which meets slave answers that end before the sample point, start after it, or span it. In each case the result is judged against the line level the model predicts two clocks before the sample edge.

// File: rtl/sw_bus_pkg.sv
package sw_bus_pkg;

  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_RST_LOW,
    SEQ_RST_LISTEN,
    SEQ_BIT_LOW,
    SEQ_BIT_REC
  } seq_state_e;

  typedef struct packed {
    logic is_reset;
    logic bit_val;
  } bus_cmd_t;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/sw_us_tick.sv
module sw_us_tick #(
  parameter int CLK_PER_US = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  localparam int CW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLK_PER_US - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (restart || cnt == LAST) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign tick = !restart && (cnt == LAST);
endmodule

// File: rtl/sw_line_sync.sv
module sw_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic line_q
);
  logic [STAGES-1:0] sr;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr <= '1;
        else        sr <= line_in;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr <= '1;
        else        sr <= {sr[STAGES-2:0], line_in};
      end
    end
  endgenerate

  assign line_q = sr[STAGES-1];
endmodule

// File: rtl/sw_slot_seq.sv
module sw_slot_seq
  import sw_bus_pkg::*;
#(
  parameter int RST_LOW_US     = 480,
  parameter int RST_RX_US      = 480,
  parameter int PRES_SAMPLE_US = 70,
  parameter int ONE_LOW_US     = 6,
  parameter int ZERO_LOW_US    = 60,
  parameter int SLOT_US        = 65
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tick,
  input  logic     cmd_go,
  input  bus_cmd_t cmd,
  input  logic     line_q,
  output logic     busy,
  output logic     done,
  output logic     drive_low,
  output logic     presence
);
  localparam int US_MAX = max3(RST_LOW_US, RST_RX_US, SLOT_US);
  localparam int UW     = $clog2(US_MAX + 1);

  localparam logic [UW-1:0] RL_END   = UW'(RST_LOW_US - 1);
  localparam logic [UW-1:0] RX_END   = UW'(RST_RX_US - 1);
  localparam logic [UW-1:0] PS_AT    = UW'(PRES_SAMPLE_US - 1);
  localparam logic [UW-1:0] ONE_END  = UW'(ONE_LOW_US - 1);
  localparam logic [UW-1:0] ZERO_END = UW'(ZERO_LOW_US - 1);
  localparam logic [UW-1:0] SLOT_END = UW'(SLOT_US - 1);

  seq_state_e    state;
  logic [UW-1:0] us;
  logic          lat_bit;
  logic [UW-1:0] bit_low_end;

  assign bit_low_end = lat_bit ? ONE_END : ZERO_END;
  assign busy        = (state != SEQ_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= SEQ_IDLE;
      us        <= '0;
      lat_bit   <= 1'b0;
      drive_low <= 1'b0;
      done      <= 1'b0;
      presence  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        SEQ_IDLE: begin
          if (cmd_go) begin
            us        <= '0;
            drive_low <= 1'b1;
            lat_bit   <= cmd.bit_val;
            if (cmd.is_reset) begin
              state    <= SEQ_RST_LOW;
              presence <= 1'b0;
            end else begin
              state <= SEQ_BIT_LOW;
            end
          end
        end
        SEQ_RST_LOW: begin
          if (tick) begin
            if (us == RL_END) begin
              us        <= '0;
              drive_low <= 1'b0;
              state     <= SEQ_RST_LISTEN;
            end else begin
              us <= us + 1'b1;
            end
          end
        end
        SEQ_RST_LISTEN: begin
          if (tick) begin
            if (us == PS_AT) presence <= ~line_q;
            if (us == RX_END) begin
              state <= SEQ_IDLE;
              done  <= 1'b1;
            end else begin
              us <= us + 1'b1;
            end
          end
        end
        SEQ_BIT_LOW: begin
          if (tick) begin
            if (us == bit_low_end) begin
              drive_low <= 1'b0;
              state     <= SEQ_BIT_REC;
            end
            us <= us + 1'b1;
          end
        end
        SEQ_BIT_REC: begin
          if (tick) begin
            if (us == SLOT_END) begin
              state <= SEQ_IDLE;
              done  <= 1'b1;
            end else begin
              us <= us + 1'b1;
            end
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sw_bus_master.sv
module sw_bus_master
  import sw_bus_pkg::*;
#(
  parameter int CLK_PER_US     = 50,
  parameter int RST_LOW_US     = 480,
  parameter int RST_RX_US      = 480,
  parameter int PRES_SAMPLE_US = 70,
  parameter int ONE_LOW_US     = 6,
  parameter int ZERO_LOW_US    = 60,
  parameter int SLOT_US        = 65,
  parameter int SYNC_STAGES    = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_valid,
  output logic cmd_ready,
  input  logic cmd_reset,
  input  logic cmd_bit,
  output logic busy,
  output logic done,
  output logic presence,
  output logic line_drive_low,
  input  logic line_in
);
  logic     go;
  logic     us_tick;
  logic     line_q;
  bus_cmd_t cmd;

  assign cmd_ready    = !busy;
  assign go           = cmd_valid && cmd_ready;
  assign cmd.is_reset = cmd_reset;
  assign cmd.bit_val  = cmd_bit;

  sw_us_tick #(.CLK_PER_US(CLK_PER_US)) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (go),
    .tick    (us_tick)
  );

  sw_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .line_in (line_in),
    .line_q  (line_q)
  );

  sw_slot_seq #(
    .RST_LOW_US     (RST_LOW_US),
    .RST_RX_US      (RST_RX_US),
    .PRES_SAMPLE_US (PRES_SAMPLE_US),
    .ONE_LOW_US     (ONE_LOW_US),
    .ZERO_LOW_US    (ZERO_LOW_US),
    .SLOT_US        (SLOT_US)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (us_tick),
    .cmd_go    (go),
    .cmd       (cmd),
    .line_q    (line_q),
    .busy      (busy),
    .done      (done),
    .drive_low (line_drive_low),
    .presence  (presence)
  );
endmodule

// File: rtl/sw_bus_master_chk.sv
module sw_bus_master_chk #(
  parameter int CLK_PER_US  = 50,
  parameter int RST_LOW_US  = 480,
  parameter int RST_RX_US   = 480,
  parameter int ONE_LOW_US  = 6,
  parameter int ZERO_LOW_US = 60,
  parameter int SLOT_US     = 65
) (
  input logic clk,
  input logic rst_n,
  input logic cmd_valid,
  input logic cmd_ready,
  input logic cmd_reset,
  input logic cmd_bit,
  input logic busy,
  input logic done,
  input logic presence,
  input logic line_drive_low
);
  localparam int RST_TOTAL = (RST_LOW_US + RST_RX_US) * CLK_PER_US;
  localparam int SLOT_TOT  = SLOT_US * CLK_PER_US;
  localparam int RST_LOW_C = RST_LOW_US * CLK_PER_US;
  localparam int ONE_C     = ONE_LOW_US * CLK_PER_US;
  localparam int ZERO_C    = ZERO_LOW_US * CLK_PER_US;

  logic        acc;
  logic        cur_rst;
  logic        cur_bit;
  logic [31:0] busy_cnt;
  logic [31:0] low_cnt;

  assign acc = cmd_valid && cmd_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_rst  <= 1'b0;
      cur_bit  <= 1'b0;
      busy_cnt <= '0;
      low_cnt  <= '0;
    end else if (acc) begin
      cur_rst  <= cmd_reset;
      cur_bit  <= cmd_bit;
      busy_cnt <= '0;
      low_cnt  <= '0;
    end else begin
      if (busy)           busy_cnt <= busy_cnt + 1;
      if (line_drive_low) low_cnt  <= low_cnt + 1;
    end
  end

  a_r1_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> busy);

  a_r2_low_starts: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> line_drive_low);

  a_r7_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r7_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  // R4, R5, R6: total command length in cycles
  a_r4_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (busy_cnt == (cur_rst ? RST_TOTAL : SLOT_TOT)));

  // R2, R5, R6, R10: low phase length in cycles
  a_r10_low_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(line_drive_low) |->
      (low_cnt == (cur_rst ? RST_LOW_C : (cur_bit ? ONE_C : ZERO_C))));

  a_r8_bit_keeps_presence: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(presence) |-> cur_rst);
endmodule

bind sw_bus_master sw_bus_master_chk #(
  .CLK_PER_US  (CLK_PER_US),
  .RST_LOW_US  (RST_LOW_US),
  .RST_RX_US   (RST_RX_US),
  .ONE_LOW_US  (ONE_LOW_US),
  .ZERO_LOW_US (ZERO_LOW_US),
  .SLOT_US     (SLOT_US)
) i_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .cmd_valid      (cmd_valid),
  .cmd_ready      (cmd_ready),
  .cmd_reset      (cmd_reset),
  .cmd_bit        (cmd_bit),
  .busy           (busy),
  .done           (done),
  .presence       (presence),
  .line_drive_low (line_drive_low)
);

// File: tb/test_sw_bus_master.sv
`timescale 1ns/1ps
module test_sw_bus_master;
  localparam int P  = 4;
  localparam int RL = 480;
  localparam int RX = 480;
  localparam int PS = 70;
  localparam int L1 = 6;
  localparam int L0 = 60;
  localparam int SL = 65;
  localparam int SE = (RL + PS) * P;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic cmd_reset = 1'b0;
  logic cmd_bit = 1'b0;
  logic cmd_ready, busy, done, presence, line_drive_low;
  logic slave_low = 1'b0;
  logic line_in;

  int total = 0;
  int bad = 0;

  assign line_in = !(line_drive_low || slave_low);

  always #10 clk = ~clk;

  sw_bus_master #(.CLK_PER_US(P)) i_sw_bus_master (
    .clk            (clk),
    .rst_n          (rst_n),
    .cmd_valid      (cmd_valid),
    .cmd_ready      (cmd_ready),
    .cmd_reset      (cmd_reset),
    .cmd_bit        (cmd_bit),
    .busy           (busy),
    .done           (done),
    .presence       (presence),
    .line_drive_low (line_drive_low),
    .line_in        (line_in)
  );

  task automatic chk(input bit ok, input string tag, input int actv, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, actv, expv, $time);
    end
  endtask

  // slave responder
  bit slave_en = 0;
  int slave_dly = 0;
  int slave_len = 0;
  bit in_reset = 0;
  always @(negedge line_drive_low) begin
    if (in_reset && slave_en) begin
      repeat (slave_dly * P) @(negedge clk);
      slave_low = 1'b1;
      repeat (slave_len * P) @(negedge clk);
      slave_low = 1'b0;
    end
  end

  // behavioural reference model
  bit act = 0, kr = 0, kb = 0, mp = 0, snap = 0;
  int e = 0;
  function automatic int tot_of(input bit r);
    return r ? (RL + RX) * P : SL * P;
  endfunction
  function automatic int low_of(input bit r, input bit b);
    return (r ? RL : (b ? L1 : L0)) * P;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      act = 0; mp = 0; e = 0;
    end else begin
      bit rdy;
      rdy = !(act && e < tot_of(kr));
      if (act && kr && e == SE - 2) snap = !line_in;
      if (rdy && cmd_valid) begin
        act = 1; e = 0; kr = cmd_reset; kb = cmd_bit;
        if (cmd_reset) mp = 0;
      end else if (act) begin
        e++;
        if (kr && e == SE) mp = snap;
      end
    end
  end

  // per-cycle comparison
  bit cmp_on = 0;
  always @(negedge clk) begin
    if (cmp_on) begin
      bit eb, ed, edn, ep;
      string tl, tb, tp;
      eb  = act && e < tot_of(kr);
      ed  = act && e < low_of(kr, kb);
      edn = act && e == tot_of(kr);
      ep  = mp;
      tl  = !act ? "R9" : (kr ? "R2" : (kb ? "R5" : "R6"));
      tb  = !act ? "R9" : (kr ? "R4" : (kb ? "R5" : "R6"));
      tp  = !act ? "R9" : (kr ? "R3" : "R8");
      chk(line_drive_low == ed, tl, line_drive_low, ed);
      chk(busy == eb, tb, busy, eb);
      chk(done == edn, "R7", done, edn);
      chk(cmd_ready == !eb, "R1", cmd_ready, !eb);
      chk(presence == ep, tp, presence, ep);
    end
  end

  // low-run length measurement
  int run = 0;
  int last_low = 0;
  always @(negedge clk) begin
    if (line_drive_low) run++;
    else if (run != 0) begin last_low = run; run = 0; end
  end

  // called at a negedge; returns at the negedge after acceptance, valid still high
  task automatic issue(input bit r, input bit b);
    bit took;
    cmd_valid = 1'b1; cmd_reset = r; cmd_bit = b; in_reset = r;
    took = 0;
    while (!took) begin
      took = cmd_ready;
      @(negedge clk);
    end
  endtask

  task automatic finish_cmd();
    cmd_valid = 1'b0;
    while (!done) @(negedge clk);
    chk(cmd_ready && !busy, "R7", cmd_ready, 1);
    @(negedge clk);
    chk(!done, "R7", done, 0);
  endtask

  task automatic do_reset(input bit en, input int dly, input int len, input bit expect_p);
    slave_en = en; slave_dly = dly; slave_len = len;
    issue(1'b1, 1'b0);
    chk(presence == 0, "R3", presence, 0);
    finish_cmd();
    chk(last_low == RL * P, "R2", last_low, RL * P);
    chk(presence == expect_p, "R3", presence, expect_p);
    slave_en = 0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !line_drive_low && !presence, "R9", busy, 0);
    chk(cmd_ready == 1, "R9", cmd_ready, 1);
    cmp_on = 1;

    // R3: answer spanning the sample point
    do_reset(1, 30, 120, 1'b1);
    // R8: bit commands leave presence alone
    issue(1'b0, 1'b1);
    finish_cmd();
    chk(last_low == L1 * P, "R10", last_low, L1 * P);
    chk(presence == 1, "R8", presence, 1);
    issue(1'b0, 1'b0);
    finish_cmd();
    chk(last_low == L0 * P, "R6", last_low, L0 * P);
    chk(presence == 1, "R8", presence, 1);

    // R3: no slave, early answer, late answer
    do_reset(0, 0, 0, 1'b0);
    do_reset(1, 15, 40, 1'b0);
    do_reset(1, 100, 60, 1'b0);
    do_reset(1, 20, 200, 1'b1);

    // R7 / R1: back-to-back with valid held through done
    issue(1'b0, 1'b1);
    issue(1'b0, 1'b0);
    issue(1'b0, 1'b1);
    issue(1'b0, 1'b0);
    finish_cmd();
    chk(presence == 1, "R8", presence, 1);

    // R1: reset held valid behind a bit command
    issue(1'b0, 1'b1);
    issue(1'b1, 1'b0);
    finish_cmd();
    chk(presence == 0, "R3", presence, 0);

    repeat (10) @(negedge clk);
    cmp_on = 0;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule